// File: doc/BRIEF.md
# Ring Oscillator Pair Comparator with Stable-Pair Selection

This block derives per-chip bits from manufacturing spread between ring oscillators. A challenge names two of the N ring inputs. The first is the "top" ring and the second is the "bottom" ring. Each selected ring is resynchronised into the system clock and its rising edges are counted for a programmable number of clocks. The block then reports whether the top ring produced more edges than the bottom ring. The rings are enabled through a shared active-low line, and only while a count window is open.

The block has three operating modes:
- **Single query** answers one challenge.
- **Enrollment** answers one challenge and also flags whether the two counts are far enough apart to trust. The pair is judged stable when the absolute count difference reaches a programmable margin.
- **Regeneration** walks a fixed list of candidate pairs using an externally supplied stability mask. It measures only the pairs marked stable and shifts each resulting bit into a key register. It signals ready once the requested number of bits is collected or the list runs out.

The controller has six states:
- S_IDLE waits for start. A challenge with equal indices raises the error pulse and stays in S_IDLE. A single or enroll challenge goes to S_PREP. Regeneration goes to S_PICK.
- S_PICK goes to S_FINISH when the list is exhausted or enough bits are held. It goes to S_PREP on a marked pair. On an unmarked pair it stays in S_PICK and advances to the next pair.
- S_PREP clears both counters and goes to S_RUN.
- S_RUN holds the rings enabled until the window ends, then goes to S_EVAL.
- S_EVAL presents the result. It returns to S_PICK while regeneration still needs bits, and otherwise goes to S_IDLE.
- S_FINISH raises ready and goes to S_IDLE.

Top module: `ropuf_readout`

## Requirements
- R1: The oscillator named by `top_sel` feeds the top counter and the one named by `bot_sel` feeds the bottom counter. Swapping the two indices of a widely separated pair inverts the response.
- R2: After a window of `win_len` clocks, `done` pulses for one cycle and `resp_bit` is 1 when the top edge count is strictly greater than the bottom count, and 0 otherwise.
- R3: `ring_en_n` is 1 out of reset and whenever no window is open. It is 0 throughout a count window, and it is 1 again in the cycle `done` is presented.
- R4: `op_mode` uses these encodings: 0 is single query, 1 is enrollment, 2 is regeneration, and 3 behaves as single query. In enrollment, `mask_bit` is 1 together with `done` exactly when the absolute count difference is at least `margin`. In every other mode `mask_bit` stays 0, and it is never 1 without `done`.
- R5: In regeneration, candidate pair k compares oscillator 2k (top) against oscillator 2k+1 (bottom). Pairs are visited in ascending k. A pair whose bit k in `pair_mask` is 0 is skipped with no window and no `done` pulse.
- R6: Each regenerated bit enters `key_out` at bit 0, and earlier bits move one place up. When the count of collected bits reaches `want_bits`, `ready` pulses in the same cycle as the final `done`, and `key_len` equals `want_bits`.
- R7: If the pair list is exhausted before `want_bits` bits are collected, `ready` pulses alone and `key_len` gives the number collected. An all-zero mask yields `ready` with `key_len` 0 and `key_out` 0.
- R8: A single or enrollment challenge with `top_sel` equal to `bot_sel` produces a one-cycle `err` pulse with no `done`, and the rings stay disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_in | input | N_OSC | Asynchronous ring oscillator outputs |
| ring_en_n | output | 1 | Shared active-low ring enable |
| start | input | 1 | Begin an operation (sampled in idle) |
| op_mode | input | 2 | 0 single, 1 enroll, 2 regenerate, 3 as single |
| top_sel | input | clog2(N_OSC) | Challenge index of the top ring |
| bot_sel | input | clog2(N_OSC) | Challenge index of the bottom ring |
| win_len | input | WIN_W | Count window length in clocks |
| margin | input | CNT_W | Stability threshold on the count difference |
| pair_mask | input | N_OSC/2 | Stable-pair mask, bit k for pair k |
| want_bits | input | clog2(N_OSC/2+1) | Number of key bits requested |
| done | output | 1 | One-cycle pulse, result valid |
| resp_bit | output | 1 | Comparison result |
| mask_bit | output | 1 | Enrollment stability flag |
| err | output | 1 | One-cycle pulse, rejected challenge |
| ready | output | 1 | One-cycle pulse, regeneration complete |
| key_out | output | N_OSC/2 | Regenerated key bits |
| key_len | output | clog2(N_OSC/2+1) | Number of valid key bits |

## Verification
In regeneration, the last wanted bit's `done` and the completion `ready` coincide in one cycle. The exhaustion path instead raises `ready` on its own, several cycles after the last `done`. Both cases are provoked with one mask (pairs 0 and 2 marked): first asking for exactly two bits, then for four. The scoreboard holds one expected item per event cycle. Its `done` and `ready` flags must match together, so a split or merged pulse shows up as a mismatch or an unexpected event.

// File: rtl/ropuf_pkg.sv
`timescale 1ns/1ps
package ropuf_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_PICK, S_PREP, S_RUN, S_EVAL, S_FINISH
    } ro_state_e;

    localparam logic [1:0] OP_SINGLE = 2'd0;
    localparam logic [1:0] OP_ENROLL = 2'd1;
    localparam logic [1:0] OP_REGEN  = 2'd2;
endpackage

// File: rtl/ro_edge_sync.sv
`timescale 1ns/1ps
module ro_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [2:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], async_in};
    end

    assign rise = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/ro_counter.sv
`timescale 1ns/1ps
module ro_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          count <= '0;
        else if (clr)                        count <= '0;
        else if (en && inc && (count != '1)) count <= count + 1'b1;
    end
endmodule

// File: rtl/ro_pair_cmp.sv
`timescale 1ns/1ps
module ro_pair_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt_a,
    input  logic [W-1:0] cnt_b,
    input  logic [W-1:0] thr,
    output logic         a_wins,
    output logic         wide
);
    logic [W-1:0] gap;

    always_comb begin
        a_wins = cnt_a > cnt_b;
        gap    = a_wins ? (cnt_a - cnt_b) : (cnt_b - cnt_a);
        wide   = gap >= thr;
    end
endmodule

// File: rtl/ropuf_readout.sv
`timescale 1ns/1ps
module ropuf_readout
    import ropuf_pkg::*;
#(
    parameter  int N_OSC  = 8,
    parameter  int CNT_W  = 16,
    parameter  int WIN_W  = 16,
    localparam int IDX_W  = $clog2(N_OSC),
    localparam int N_PAIR = N_OSC / 2,
    localparam int PAIR_W = $clog2(N_PAIR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_OSC-1:0]  ring_in,
    output logic              ring_en_n,
    input  logic              start,
    input  logic [1:0]        op_mode,
    input  logic [IDX_W-1:0]  top_sel,
    input  logic [IDX_W-1:0]  bot_sel,
    input  logic [WIN_W-1:0]  win_len,
    input  logic [CNT_W-1:0]  margin,
    input  logic [N_PAIR-1:0] pair_mask,
    input  logic [PAIR_W-1:0] want_bits,
    output logic              done,
    output logic              resp_bit,
    output logic              mask_bit,
    output logic              err,
    output logic              ready,
    output logic [N_PAIR-1:0] key_out,
    output logic [PAIR_W-1:0] key_len
);
    localparam int PIDX_W = $clog2(N_PAIR);
    localparam logic [PAIR_W-1:0] NPAIR_V = PAIR_W'(N_PAIR);
    localparam logic [PAIR_W-1:0] ONE_P   = PAIR_W'(1);
    localparam logic [WIN_W-1:0]  ONE_W   = WIN_W'(1);

    ro_state_e         state_q, state_d;
    logic [1:0]        mode_q;
    logic [IDX_W-1:0]  top_q, bot_q;
    logic [PAIR_W-1:0] pidx_q, nbits_q, want_q;
    logic [N_PAIR-1:0] mask_q, key_q;
    logic [WIN_W-1:0]  win_q;
    logic [N_OSC-1:0]  rise_v;
    logic [CNT_W-1:0]  cnt_top, cnt_bot;
    logic              top_wins, gap_wide;

    // One synchronizer and edge detector per ring input
    for (genvar g = 0; g < N_OSC; g++) begin : g_sync
        ro_edge_sync u_sync (
            .clk(clk), .rst_n(rst_n), .async_in(ring_in[g]), .rise(rise_v[g])
        );
    end

    ro_counter #(.W(CNT_W)) u_cnt_top (
        .clk(clk), .rst_n(rst_n), .clr(state_q == S_PREP),
        .en(state_q == S_RUN), .inc(rise_v[top_q]), .count(cnt_top)
    );
    ro_counter #(.W(CNT_W)) u_cnt_bot (
        .clk(clk), .rst_n(rst_n), .clr(state_q == S_PREP),
        .en(state_q == S_RUN), .inc(rise_v[bot_q]), .count(cnt_bot)
    );
    ro_pair_cmp #(.W(CNT_W)) u_cmp (
        .cnt_a(cnt_top), .cnt_b(cnt_bot), .thr(margin),
        .a_wins(top_wins), .wide(gap_wide)
    );

    logic list_over, cur_marked, win_end, last_bit, is_regen, same_sel;
    assign is_regen   = (mode_q == OP_REGEN);
    assign same_sel   = (top_sel == bot_sel);
    assign list_over  = (pidx_q == NPAIR_V) || (nbits_q == want_q);
    assign cur_marked = mask_q[pidx_q[PIDX_W-1:0]];
    assign win_end    = (win_q + ONE_W) >= win_len;
    assign last_bit   = (nbits_q + ONE_P) == want_q;

    assign ring_en_n  = (state_q != S_RUN);
    assign key_out    = key_q;
    assign key_len    = nbits_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) begin
                if (op_mode == OP_REGEN) state_d = S_PICK;
                else if (!same_sel)      state_d = S_PREP;
            end
            S_PICK:   if (list_over)       state_d = S_FINISH;
                      else if (cur_marked) state_d = S_PREP;
            S_PREP:   state_d = S_RUN;
            S_RUN:    if (win_end) state_d = S_EVAL;
            S_EVAL:   state_d = (is_regen && !last_bit) ? S_PICK : S_IDLE;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0; resp_bit <= 1'b0; mask_bit <= 1'b0;
            err  <= 1'b0; ready    <= 1'b0;
            mode_q <= OP_SINGLE; top_q <= '0; bot_q <= '0;
            pidx_q <= '0; nbits_q <= '0; want_q <= '0;
            mask_q <= '0; key_q   <= '0; win_q  <= '0;
        end else begin
            done <= 1'b0; mask_bit <= 1'b0; err <= 1'b0; ready <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start) begin
                    mode_q <= op_mode;
                    if (op_mode == OP_REGEN) begin
                        pidx_q <= '0; nbits_q <= '0; key_q <= '0;
                        want_q <= want_bits; mask_q <= pair_mask;
                    end else if (same_sel) begin
                        err <= 1'b1;
                    end else begin
                        top_q <= top_sel; bot_q <= bot_sel;
                    end
                end
                S_PICK: if (!list_over) begin
                    if (cur_marked) begin
                        top_q <= {pidx_q[PIDX_W-1:0], 1'b0};
                        bot_q <= {pidx_q[PIDX_W-1:0], 1'b1};
                    end else begin
                        pidx_q <= pidx_q + ONE_P;
                    end
                end
                S_PREP: win_q <= '0;
                S_RUN:  win_q <= win_q + ONE_W;
                S_EVAL: begin
                    done     <= 1'b1;
                    resp_bit <= top_wins;
                    mask_bit <= (mode_q == OP_ENROLL) && gap_wide;
                    if (is_regen) begin
                        key_q   <= {key_q[N_PAIR-2:0], top_wins};
                        nbits_q <= nbits_q + ONE_P;
                        pidx_q  <= pidx_q + ONE_P;
                        ready   <= last_bit;
                    end
                end
                S_FINISH: ready <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ropuf_readout_chk.sv
`timescale 1ns/1ps
module ropuf_readout_chk #(
    parameter int PAIR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ring_en_n,
    input logic              done,
    input logic              mask_bit,
    input logic              err,
    input logic              ready,
    input logic [PAIR_W-1:0] key_len,
    input logic [PAIR_W-1:0] want_bits
);
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_rings_off_at_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ring_en_n);

    assert_mask_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_bit |-> done);

    assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    assert_len_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (key_len <= want_bits));

    assert_err_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!done && !ready && ring_en_n));
endmodule

bind ropuf_readout ropuf_readout_chk #(.PAIR_W(PAIR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ring_en_n(ring_en_n), .done(done),
    .mask_bit(mask_bit), .err(err), .ready(ready),
    .key_len(key_len), .want_bits(want_bits)
);

// File: tb/ropuf_readout_bench.sv
`timescale 1ns/1ps
module ropuf_readout_bench;
    localparam int N = 8;
    localparam int HALF [N] = '{20, 25, 30, 31, 35, 22, 45, 44};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] ring_in;
    logic ring_en_n;
    logic start = 1'b0;
    logic [1:0] op_mode = 2'd0;
    logic [2:0] top_sel = '0, bot_sel = '0;
    logic [15:0] win_len = 16'd1000;
    logic [15:0] margin = 16'd20;
    logic [3:0] pair_mask = '0;
    logic [2:0] want_bits = '0;
    logic done, resp_bit, mask_bit, err, ready;
    logic [3:0] key_out;
    logic [2:0] key_len;

    always #4 clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : g_ring
        logic o = 1'b0;
        always begin
            if (ring_en_n) begin
                o = 1'b0;
                @(negedge ring_en_n);
            end else begin
                #(HALF[g]);
                o = ~o;
            end
        end
        assign ring_in[g] = o;
    end

    ropuf_readout u_ropuf_readout (
        .clk(clk), .rst_n(rst_n), .ring_in(ring_in), .ring_en_n(ring_en_n),
        .start(start), .op_mode(op_mode), .top_sel(top_sel), .bot_sel(bot_sel),
        .win_len(win_len), .margin(margin), .pair_mask(pair_mask),
        .want_bits(want_bits), .done(done), .resp_bit(resp_bit),
        .mask_bit(mask_bit), .err(err), .ready(ready),
        .key_out(key_out), .key_len(key_len)
    );

    typedef struct packed {
        logic d, e, r, resp, mask;
        logic [3:0] key;
        logic [2:0] len;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];
    int tests = 0;
    int fails = 0;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic push(input logic d, e, r, resp, mask, input logic [3:0] key,
                        input logic [2:0] len, input string tag);
        exp_t it;
        it.d = d; it.e = e; it.r = r; it.resp = resp; it.mask = mask;
        it.key = key; it.len = len;
        exp_q.push_back(it);
        tag_q.push_back(tag);
    endtask

    // Monitor: every event cycle is compared with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && (done || err || ready)) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL unexpected event done=%b err=%b ready=%b", done, err, ready);
            end else begin
                exp_t  it;
                string tg;
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                check({tg, " flags"}, {5'd0, done, err, ready}, {5'd0, it.d, it.e, it.r});
                if (it.d) check({tg, " resp/mask"}, {6'd0, resp_bit, mask_bit}, {6'd0, it.resp, it.mask});
                if (it.r) check({tg, " key/len"}, {1'b0, key_out, key_len}, {1'b0, it.key, it.len});
            end
        end
    end

    task automatic launch(input logic [1:0] m, input logic [2:0] t, b,
                          input logic [15:0] thr, input logic [3:0] msk,
                          input logic [2:0] want);
        @(negedge clk);
        op_mode = m; top_sel = t; bot_sel = b; margin = thr;
        pair_mask = msk; want_bits = want; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (exp_q.size() != 0) begin
            tests++; fails++;
            $display("FAIL drain: %0d expected events missing, first %s", exp_q.size(), tag_q[0]);
            exp_q.delete(); tag_q.delete();
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R3 reset state
        check("R3 reset enable", {7'd0, ring_en_n}, 8'd1);
        check("R2 reset done", {7'd0, done}, 8'd0);
        check("R6 reset key", {1'b0, key_out, key_len}, 8'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1/R2: single queries, slower top gives 0, faster top gives 1
        push(1, 0, 0, 0, 0, 4'd0, 3'd0, "R2 single(1,0)");
        launch(2'd0, 3'd1, 3'd0, 16'd20, 4'd0, 3'd0);
        repeat (50) @(negedge clk);
        check("R3 enable low mid-window", {7'd0, ring_en_n}, 8'd0);
        drain();
        check("R3 enable high after result", {7'd0, ring_en_n}, 8'd1);
        push(1, 0, 0, 1, 0, 4'd0, 3'd0, "R1 swapped (0,1)");
        launch(2'd0, 3'd0, 3'd1, 16'd20, 4'd0, 3'd0);
        drain();
        push(1, 0, 0, 1, 0, 4'd0, 3'd0, "R1 single(5,6)");
        launch(2'd0, 3'd5, 3'd6, 16'd20, 4'd0, 3'd0);
        drain();
        push(1, 0, 0, 0, 0, 4'd0, 3'd0, "R2 single(6,0)");
        launch(2'd3, 3'd6, 3'd0, 16'd20, 4'd0, 3'd0);
        drain();

        // R8: identical indices rejected, rings never enabled
        push(0, 1, 0, 0, 0, 4'd0, 3'd0, "R8 same index");
        launch(2'd0, 3'd3, 3'd3, 16'd20, 4'd0, 3'd0);
        drain();
        check("R8 rings stay off", {7'd0, ring_en_n}, 8'd1);
        push(0, 1, 0, 0, 0, 4'd0, 3'd0, "R8 same index enroll");
        launch(2'd1, 3'd7, 3'd7, 16'd20, 4'd0, 3'd0);
        drain();

        // R4: enrollment stability flag
        push(1, 0, 0, 1, 1, 4'd0, 3'd0, "R4 enroll wide (0,1)");
        launch(2'd1, 3'd0, 3'd1, 16'd20, 4'd0, 3'd0);
        drain();
        push(1, 0, 0, 1, 0, 4'd0, 3'd0, "R4 enroll narrow (2,3)");
        launch(2'd1, 3'd2, 3'd3, 16'd20, 4'd0, 3'd0);
        drain();
        push(1, 0, 0, 0, 1, 4'd0, 3'd0, "R4 enroll wide (4,5)");
        launch(2'd1, 3'd4, 3'd5, 16'd20, 4'd0, 3'd0);
        drain();
        push(1, 0, 0, 1, 0, 4'd0, 3'd0, "R4 enroll high margin");
        launch(2'd1, 3'd0, 3'd1, 16'd1000, 4'd0, 3'd0);
        drain();

        // R5/R6: regeneration, ready coincides with final done
        push(1, 0, 0, 1, 0, 4'd0, 3'd0, "R5 regen pair0");
        push(1, 0, 1, 0, 0, 4'b0010, 3'd2, "R6 regen pair2 + ready");
        launch(2'd2, 3'd0, 3'd0, 16'd20, 4'b0101, 3'd2);
        drain();
        push(1, 0, 1, 0, 0, 4'b0000, 3'd1, "R5 regen skip to pair2");
        launch(2'd2, 3'd0, 3'd0, 16'd20, 4'b0100, 3'd1);
        drain();

        // R7: list exhausted, and empty mask
        push(1, 0, 0, 1, 0, 4'd0, 3'd0, "R7 regen pair0");
        push(1, 0, 0, 0, 0, 4'd0, 3'd0, "R7 regen pair2");
        push(0, 0, 1, 0, 0, 4'b0010, 3'd2, "R7 exhausted ready");
        launch(2'd2, 3'd0, 3'd0, 16'd20, 4'b0101, 3'd4);
        drain();
        push(0, 0, 1, 0, 0, 4'b0000, 3'd0, "R7 empty mask");
        launch(2'd2, 3'd0, 3'd0, 16'd20, 4'b0000, 3'd3);
        drain();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule